// File: doc/BRIEF.md
# Pulse-Pause Reader Frame Encoder

This block sends a short command frame from a reader to a card by switching the carrier on and off. Every bit opens with a fixed gap in which the carrier is off. The carrier then comes back on, and the length of that on-time tells the card whether the bit is a one or a zero. After the last bit, one more gap with no data closes the frame.

Before a frame goes out, the payload is combined by XOR with a keystream word supplied from outside, bit for bit over the requested length. The first frame of a session is a 7-bit opening word. It is sent with an all-zero keystream, so it goes out unchanged.

All durations are counted in pulses of a one-microsecond enable that is derived from the system clock. The modulation output is the only line that reaches the carrier switch. `busy` marks the frame in progress, and `done` reports that the frame has ended.

Top module: `pp_frame_enc`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mod_out` is 1 (carrier on) and `busy` and `done` are 0.
- R2: A `start` pulse is accepted while idle when `nbits` is between 1 and 16. In the first clock after that pulse, `busy` is 1 and `mod_out` is 0.
- R3: Each bit opens with a carrier-off gap that lasts exactly 20 `tick_us` pulses.
- R4: After its gap, a bit of value 1 holds the carrier on for 80 ticks, giving 100 in total. A bit of value 0 holds it on for 40 ticks, giving 60 in total.
- R5: Exactly `nbits` bits are sent, starting with bit 0 of the whitened word (least significant first).
- R6: Transmitted bit i equals `payload[i] ^ keystream[i]`. Keystream bits at index `nbits` and above have no effect.
- R7: With an all-zero keystream, a 7-bit payload is sent unchanged.
- R8: After the carrier-on time of the last bit, one further carrier-off gap of 20 ticks closes the frame.
- R9: `done` is 1 for exactly one clock. That clock follows the last tick of the closing gap and is the same clock in which `busy` returns to 0.
- R10: A `start` pulse that arrives while `busy` is 1 is ignored. The running frame is unchanged and no further frame follows.
- R11: A `start` pulse with `nbits` equal to 0 or greater than 16 is ignored, and `busy` stays 0.
- R12: Time advances only on `tick_us` pulses. Changing the tick spacing stretches every interval, but the tick counts of R3, R4 and R8 stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-clock enable pulse, once per microsecond |
| start | input | 1 | Request to send one frame |
| payload | input | 16 | Frame data, bit 0 sent first |
| nbits | input | 5 | Number of bits to send (1 to 16) |
| keystream | input | 16 | Whitening bits, XORed with the payload |
| mod_out | output | 1 | Carrier control: 1 = on, 0 = off |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when the frame ends |

## Verification
A bad gap or on-time counter shows up within a single bit as a low or high run of the wrong length in ticks. A bad bit counter, shift register or XOR shows up at the end of the frame, as a wrong bit count or a wrong decoded word. A controller that leaves idle when it should not (an ignored start, or a bad count) shows up as `busy` rising, or as an extra frame with no matching expected item. The ends of a frame are checked on their own: `done` must line up with the fall of `busy`, right after the 20-tick closing gap.

// File: rtl/pp_enc_pkg.sv
`timescale 1ns/1ps
package pp_enc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_ON    = 2'd2,
    ST_CLOSE = 2'd3
  } enc_st_e;
endpackage

// File: rtl/pp_tick_timer.sv
`timescale 1ns/1ps
module pp_tick_timer #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Fires on the tick that completes the interval.
  assign expire = tick && (cnt_q == limit - 1'b1);

  // The interval counter never reaches the active limit.
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
endmodule

// File: rtl/pp_shift.sv
`timescale 1ns/1ps
module pp_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] payload,
  input  logic [DATA_W-1:0] keystream,
  output logic              cur_bit
);
  logic [DATA_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load)          sreg_d = payload ^ keystream;
    else if (shift_en) sreg_d = sreg_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign cur_bit = sreg_q[0];
endmodule

// File: rtl/pp_enc_ctrl.sv
`timescale 1ns/1ps
module pp_enc_ctrl
  import pp_enc_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int CNT_W    = 5,
  parameter int TW       = 7,
  parameter int GAP_T    = 20,
  parameter int ONE_T    = 80,
  parameter int ZERO_T   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nbits,
  input  logic             expire,
  input  logic             cur_bit,
  output logic             load,
  output logic             shift_en,
  output logic             clr,
  output logic [TW-1:0]    limit,
  output logic             mod_out,
  output logic             busy,
  output logic             done
);
  enc_st_e          st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             mod_q, mod_d;
  logic             done_q, done_d;
  logic             cnt_ok;

  assign cnt_ok = (nbits != '0) && (nbits <= CNT_W'(MAX_BITS));

  always_comb begin
    st_d     = st_q;
    left_d   = left_q;
    load     = 1'b0;
    shift_en = 1'b0;
    clr      = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        clr = 1'b1;
        if (start && cnt_ok) begin
          st_d   = ST_GAP;
          load   = 1'b1;
          left_d = nbits;
        end
      end
      ST_GAP: begin
        if (expire) begin
          st_d = ST_ON;
          clr  = 1'b1;
        end
      end
      ST_ON: begin
        if (expire) begin
          clr      = 1'b1;
          shift_en = 1'b1;
          left_d   = left_q - 1'b1;
          st_d     = (left_q == CNT_W'(1)) ? ST_CLOSE : ST_GAP;
        end
      end
      ST_CLOSE: begin
        if (expire) begin
          clr    = 1'b1;
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_q == ST_ON) limit = cur_bit ? TW'(ONE_T) : TW'(ZERO_T);
    else               limit = TW'(GAP_T);
  end

  assign mod_d = !((st_d == ST_GAP) || (st_d == ST_CLOSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      mod_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      mod_q  <= mod_d;
      done_q <= done_d;
    end
  end

  assign mod_out = mod_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;

  assert_rest_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mod_out);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_bad_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !cnt_ok) |=> !busy);
endmodule

// File: rtl/pp_frame_enc.sv
`timescale 1ns/1ps
module pp_frame_enc #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = $clog2(DATA_W + 1),
  parameter int GAP_US     = 20,
  parameter int ONE_ON_US  = 80,
  parameter int ZERO_ON_US = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              start,
  input  logic [DATA_W-1:0] payload,
  input  logic [CNT_W-1:0]  nbits,
  input  logic [DATA_W-1:0] keystream,
  output logic              mod_out,
  output logic              busy,
  output logic              done
);
  localparam int LIM_A   = (ONE_ON_US > ZERO_ON_US) ? ONE_ON_US : ZERO_ON_US;
  localparam int LIM_MAX = (LIM_A > GAP_US) ? LIM_A : GAP_US;
  localparam int TW      = $clog2(LIM_MAX + 1);

  logic          load, shift_en, clr, expire, cur_bit;
  logic [TW-1:0] limit;

  pp_enc_ctrl #(
    .MAX_BITS(DATA_W), .CNT_W(CNT_W), .TW(TW),
    .GAP_T(GAP_US), .ONE_T(ONE_ON_US), .ZERO_T(ZERO_ON_US)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits),
    .expire(expire), .cur_bit(cur_bit), .load(load), .shift_en(shift_en),
    .clr(clr), .limit(limit), .mod_out(mod_out), .busy(busy), .done(done)
  );

  pp_tick_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .clr(clr),
    .limit(limit), .expire(expire)
  );

  pp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .payload(payload), .keystream(keystream), .cur_bit(cur_bit)
  );

  // A new frame is only loaded from idle.
  assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: tb/sim_pp_frame_enc.sv
`timescale 1ns/1ps
module sim_pp_frame_enc;
  localparam int GAP = 20, ONE = 80, ZERO = 40;

  logic        clk, rst_n, tick_us, start;
  logic [15:0] payload, keystream;
  logic [4:0]  nbits;
  logic        mod_out, busy, done;

  int checks = 0, fails = 0, tdiv = 3;
  logic [15:0] exp_q[$];
  int          expn_q[$];

  pp_frame_enc u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
    .payload(payload), .nbits(nbits), .keystream(keystream),
    .mod_out(mod_out), .busy(busy), .done(done)
  );

  initial begin clk = 0; forever #4 clk = ~clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator, changed just after the rising edge
  initial begin
    int c;
    c = 0; tick_us = 0;
    forever begin
      @(posedge clk); #1;
      c = (c + 1 >= tdiv) ? 0 : c + 1;
      tick_us = (c == 0);
    end
  end

  // monitor: decode runs of mod_out in ticks, compare with scoreboard
  bit          in_frame = 0;
  logic        prev;
  int          run, bitpos;
  logic [15:0] dec;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !(in_frame && !busy))
        chk(0, "R9 stray done", 1, 0);
      if (!busy && !in_frame && !mod_out)
        chk(0, "R1 idle carrier", 0, 1);
      if (busy) begin
        if (!in_frame) begin
          in_frame = 1; run = 0; bitpos = 0; dec = '0; prev = mod_out;
        end
        if (mod_out != prev) begin
          if (!prev) chk(run == GAP, "R3 gap ticks", run, GAP);
          else begin
            chk(run == ONE || run == ZERO, "R4 on ticks", run, ONE);
            if (bitpos < 16) dec[bitpos] = (run == ONE);
            bitpos++;
          end
          run = 0;
        end
        if (tick_us) run++;
        prev = mod_out;
      end else if (in_frame) begin
        in_frame = 0;
        chk(!prev && run == GAP, "R8 closing gap", run, GAP);
        chk(done, "R9 done with busy fall", done, 1);
        if (exp_q.size() == 0) chk(0, "R10 unexpected frame", 1, 0);
        else begin
          logic [15:0] e;
          int n;
          e = exp_q.pop_front();
          n = expn_q.pop_front();
          chk(bitpos == n, "R5 bit count", bitpos, n);
          chk(dec == e, "R6 whitened data", dec, e);
        end
      end
    end
  end

  task automatic send(input logic [15:0] p, input logic [15:0] k,
                      input int n, input bit wait_end);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
    payload = p; keystream = k; nbits = 5'(n); start = 1;
    exp_q.push_back((p ^ k) & 16'((32'd1 << n) - 1));
    expn_q.push_back(n);
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(busy && !mod_out, "R2 start response", {busy, mod_out}, 2);
    if (wait_end) begin
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic bad_start(input int n);
    @(posedge clk); #1;
    payload = 16'hFFFF; keystream = 16'h0; nbits = 5'(n); start = 1;
    @(posedge clk); #1 start = 0;
    repeat (3) @(negedge clk);
    chk(!busy && mod_out, "R11 bad count ignored", busy, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; payload = '0; keystream = '0; nbits = '0;
    repeat (4) @(negedge clk);
    chk(mod_out && !busy && !done, "R1 reset state", {mod_out, busy, done}, 4);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mod_out && !busy, "R1 idle after reset", {mod_out, busy}, 2);

    send(16'h0055, 16'h0000, 7, 1);          // R7 opening word, zero keystream
    send(16'hA5C3, 16'h0F0F, 16, 1);         // R6 full width
    send(16'h0001, 16'h0000, 1, 1);          // R5 single one bit
    send(16'h0001, 16'h0001, 1, 1);          // R6 whitened to zero
    send(16'h0003, 16'hFFF0, 4, 1);          // R6 high keystream bits unused
    tdiv = 5;
    send(16'h003C, 16'h0081, 8, 1);          // R12 slower ticks
    tdiv = 1;
    send(16'hFFFF, 16'h0000, 16, 1);         // R12 tick every clock
    tdiv = 3;
    send(16'h1234, 16'h0000, 16, 0);         // R10 start during frame
    repeat (300) @(negedge clk);
    @(posedge clk); #1;
    payload = 16'hFFFF; nbits = 5'd3; start = 1;
    @(posedge clk); #1 start = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    bad_start(0);                             // R11
    bad_start(17);                            // R11
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all frames seen, none extra", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule